// File: doc/BRIEF.md
# Two-Phase Serial Debug Scan Chain

This block gives a tester serial access to a small bank of 32-bit register rows inside a datapath. A binary row address picks one row. A read strobe copies that row in parallel into a scan register. Two non-overlapping shift strobes then clock the scan register out one bit per step. The scan register has a master stage, which the A strobe loads from the serial input, and a slave output bit, which the B strobe loads from the master's top bit. A write strobe copies the scan register back into the addressed row. This lets a tester read a row and replace it in one pass.

Every strobe is a level input that is sampled on the system clock. Shift actions happen on the sampled rising edge of a strobe. The serial output is enabled only while the B strobe is high, so several chains can share one tester pin. A hold input freezes the shift stages. Row 7 is the row a pipeline result register would occupy in the default configuration. It behaves like every other row.

Top module: `dbg_scan_chain`

## Requirements
- R1: After reset all rows and the scan register hold zero, `scan_oe` is low and `scan_out` is low.
- R2: When `rd_stb` is sampled high with both shift strobes low, the row selected by the binary value of `row_sel` is copied into the scan register on that clock edge.
- R3: On a sampled rising edge of `shift_b` (A low, hold low), the scan register's most significant bit appears on `scan_out` from the next cycle on. It stays steady while `shift_b` stays high, and a B phase never changes the scan register.
- R4: `scan_oe` is high in the cycle after `shift_b` is sampled high and low in the cycle after it is sampled low. `scan_out` is driven low whenever `scan_oe` is low.
- R5: On a sampled rising edge of `shift_a` (B low, hold low), the scan register shifts one place toward its MSB and takes `scan_in` into bit 0. After 32 B/A bit steps the whole word has left MSB first and has been fully replaced.
- R6: When `wr_stb` is sampled high with `rd_stb` and both shift strobes low, the scan register is copied into the selected row.
- R7: When `rd_stb` and `wr_stb` are both high, only the read takes place and the row keeps its contents.
- R8: Read and write strobes have no effect on the scan register or on any row while `shift_a` or `shift_b` is high.
- R9: While `hold` is high, strobe edges neither shift the scan register nor change the output bit. The output enable still follows B.
- R10: If A and B are sampled high in the same cycle, neither edge acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_sel | input | 3 | Binary row address |
| rd_stb | input | 1 | Copy selected row into the scan register |
| wr_stb | input | 1 | Copy scan register into the selected row |
| hold | input | 1 | Freeze the shift stages |
| shift_a | input | 1 | Master strobe: sample `scan_in` |
| shift_b | input | 1 | Slave strobe: present the MSB |
| scan_in | input | 1 | Serial data in |
| scan_out | output | 1 | Serial data out, valid while `scan_oe` is high |
| scan_oe | output | 1 | Output enable for the tristate pad driver |

## Verification
The bench writes a distinct computed pattern into every row through the chain and reads each row back. A design that shifted LSB first, or that lost or doubled a step, would return a rotated or shifted pattern. Simultaneous read and write is checked against a later reread of the row, because a design that let the write win would corrupt the row. Read and write pulses are placed inside the B and A phases; a design that honoured them would reload the register mid-scan or overwrite an unrelated row. Full bit steps taken under hold, and a step with A and B overlapping, must leave the next full scan identical to the stored row; a design that shifted anyway would drop the top bit.

// File: rtl/dscan_pkg.sv
package dscan_pkg;

    localparam int DEF_SCAN_W   = 32;
    localparam int DEF_NUM_ROWS = 8;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_PRESENT,
        EV_SAMPLE
    } shift_ev_t;

endpackage

// File: rtl/dscan_rowbank.sv
module dscan_rowbank #(
    parameter int W    = dscan_pkg::DEF_SCAN_W,
    parameter int ROWS = dscan_pkg::DEF_NUM_ROWS,
    localparam int AW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] sel,
    input  logic          rd_stb,
    input  logic          wr_stb,
    input  logic          busy,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  rd_data,
    output logic          load_en
);

    logic [ROWS-1:0][W-1:0] rows_d, rows_q;
    logic [ROWS-1:0]        row_hit;
    logic                   wr_go;

    for (genvar g = 0; g < ROWS; g++) begin : g_hit
        assign row_hit[g] = (sel == AW'(g));
    end

    always_comb begin
        wr_go   = wr_stb && !rd_stb && !busy;
        load_en = rd_stb && !busy;
        rows_d  = rows_q;
        rd_data = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (row_hit[i]) begin
                rd_data = rows_q[i];
                if (wr_go) begin
                    rows_d[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rows_q <= '0;
        end else begin
            rows_q <= rows_d;
        end
    end

    // R7 / R8: rows only change on a lone write outside the shift phases
    p_rows_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy || !wr_stb || rd_stb) |=> $stable(rows_q));

endmodule

// File: rtl/dscan_shifter.sv
module dscan_shifter #(
    parameter int W = dscan_pkg::DEF_SCAN_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_data,
    input  logic         hold,
    input  logic         strb_a,
    input  logic         strb_b,
    input  logic         ser_in,
    output logic         ser_out,
    output logic         ser_oe,
    output logic [W-1:0] shreg
);
    import dscan_pkg::*;

    typedef struct packed {
        logic [W-1:0] sr;
        logic         out_bit;
        logic         a_seen;
        logic         b_seen;
    } shift_st_t;

    shift_st_t st_d, st_q;
    shift_ev_t ev;

    always_comb begin
        ev = EV_NONE;
        if (!hold && !(strb_a && strb_b)) begin
            if (strb_b && !st_q.b_seen) begin
                ev = EV_PRESENT;
            end else if (strb_a && !st_q.a_seen) begin
                ev = EV_SAMPLE;
            end
        end

        st_d        = st_q;
        st_d.a_seen = strb_a;
        st_d.b_seen = strb_b;
        if (load_en) begin
            st_d.sr = load_data;
        end
        case (ev)
            EV_PRESENT: st_d.out_bit = st_q.sr[W-1];
            EV_SAMPLE:  st_d.sr      = {st_q.sr[W-2:0], ser_in};
            default:    ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_oe  = st_q.b_seen;
    assign ser_out = st_q.b_seen & st_q.out_bit;
    assign shreg   = st_q.sr;

    // R4: enable follows the sampled B strobe one cycle later
    p_oe_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        strb_b |=> ser_oe);
    p_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_b |=> !ser_oe);

    // R3: a B phase never moves the master stage
    p_b_keeps_sr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_b && !load_en) |=> $stable(st_q.sr));

    // R3: output steady while B remains high
    p_out_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_oe && strb_b) |=> $stable(ser_out));

    // R9: hold freezes both stages
    p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !load_en) |=> ($stable(st_q.sr) && $stable(st_q.out_bit)));

endmodule

// File: rtl/dbg_scan_chain.sv
module dbg_scan_chain #(
    parameter int SCAN_W   = dscan_pkg::DEF_SCAN_W,
    parameter int NUM_ROWS = dscan_pkg::DEF_NUM_ROWS,
    localparam int ADDR_W  = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] row_sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic              hold,
    input  logic              shift_a,
    input  logic              shift_b,
    input  logic              scan_in,
    output logic              scan_out,
    output logic              scan_oe
);

    logic              busy;
    logic              load_en;
    logic [SCAN_W-1:0] row_word;
    logic [SCAN_W-1:0] shreg;

    assign busy = shift_a | shift_b;

    dscan_rowbank #(
        .W    (SCAN_W),
        .ROWS (NUM_ROWS)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (row_sel),
        .rd_stb  (rd_stb),
        .wr_stb  (wr_stb),
        .busy    (busy),
        .wr_data (shreg),
        .rd_data (row_word),
        .load_en (load_en)
    );

    dscan_shifter #(
        .W (SCAN_W)
    ) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_data (row_word),
        .hold      (hold),
        .strb_a    (shift_a),
        .strb_b    (shift_b),
        .ser_in    (scan_in),
        .ser_out   (scan_out),
        .ser_oe    (scan_oe),
        .shreg     (shreg)
    );

    // R4: released output is parked low
    p_parked_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_oe |-> !scan_out);

endmodule

// File: tb/dbg_scan_chain_tb_top.sv
module dbg_scan_chain_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] row_sel = '0;
    logic       rd_stb = 1'b0, wr_stb = 1'b0, hold = 1'b0;
    logic       shift_a = 1'b0, shift_b = 1'b0, scan_in = 1'b0;
    logic       scan_out, scan_oe;
    int         errs = 0;
    int         checks = 0;

    always #10 clk = ~clk;

    dbg_scan_chain dut_i (
        .clk(clk), .rst_n(rst_n), .row_sel(row_sel), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .hold(hold), .shift_a(shift_a), .shift_b(shift_b),
        .scan_in(scan_in), .scan_out(scan_out), .scan_oe(scan_oe)
    );

    function automatic logic [31:0] pat(int r);
        return 32'h9E3779B9 * 32'(r + 1);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_row(int r);
        @(negedge clk) row_sel = 3'(r); rd_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0;
    endtask

    task automatic write_row(int r);
        @(negedge clk) row_sel = 3'(r); wr_stb = 1'b1;
        @(negedge clk) wr_stb = 1'b0;
    endtask

    task automatic shift_bit(logic din, logic exp, string req);
        @(negedge clk) shift_b = 1'b1;
        @(negedge clk);
        chk("R4 oe high in B", 32'(scan_oe), 32'd1);
        chk(req, 32'(scan_out), 32'(exp));
        @(negedge clk);
        chk("R3 bit steady", 32'(scan_out), 32'(exp));
        shift_b = 1'b0;
        @(negedge clk);
        chk("R4 released", 32'({scan_oe, scan_out}), 32'd0);
        shift_a = 1'b1; scan_in = din;
        @(negedge clk) shift_a = 1'b0;
    endtask

    task automatic scan_bits(logic [31:0] din, logic [31:0] exp, int n, string req);
        for (int i = n - 1; i >= 0; i--) begin
            shift_bit(din[i], exp[i], req);
        end
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", 32'(scan_oe), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", 32'({scan_oe, scan_out}), 32'd0);

        // R1/R2/R5/R6: rows start at zero; fill each through the chain
        for (int r = 0; r < 8; r++) begin
            read_row(r);
            scan_bits(pat(r), 32'd0, 32, "R1 row zero");
            write_row(r);
        end
        // R2/R5/R6: read every row back MSB first
        for (int r = 0; r < 8; r++) begin
            read_row(r);
            scan_bits(~pat(r), pat(r), 32, "R2 R5 R6 row readback");
        end

        // R7: read wins over a simultaneous write
        @(negedge clk) row_sel = 3'd3; rd_stb = 1'b1; wr_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0; wr_stb = 1'b0;
        scan_bits(32'd0, pat(3), 32, "R7 read taken");
        read_row(3);
        scan_bits(32'd0, pat(3), 32, "R7 row intact");

        // R8: strobes inside shift phases are ignored
        read_row(1);
        @(negedge clk) shift_b = 1'b1; rd_stb = 1'b1; row_sel = 3'd2;
        @(negedge clk) rd_stb = 1'b0;
        chk("R3 first bit", 32'(scan_out), 32'(pat(1)[31]));
        shift_b = 1'b0;
        @(negedge clk) shift_a = 1'b1; scan_in = 1'b0; wr_stb = 1'b1; row_sel = 3'd4;
        @(negedge clk) shift_a = 1'b0; wr_stb = 1'b0;
        scan_bits(32'd0, pat(1), 31, "R8 read ignored");
        read_row(4);
        scan_bits(32'd0, pat(4), 32, "R8 write ignored");

        // R9: a full bit step under hold does nothing to the data
        read_row(5);
        @(negedge clk) hold = 1'b1; shift_b = 1'b1;
        @(negedge clk);
        chk("R9 oe follows B under hold", 32'(scan_oe), 32'd1);
        shift_b = 1'b0;
        @(negedge clk) shift_a = 1'b1; scan_in = 1'b1;
        @(negedge clk) shift_a = 1'b0;
        @(negedge clk) hold = 1'b0;
        scan_bits(32'hFFFF_FFFF, pat(5), 32, "R9 hold froze");

        // R10: overlapping strobes do nothing
        read_row(6);
        @(negedge clk) shift_a = 1'b1; shift_b = 1'b1; scan_in = 1'b1;
        @(negedge clk) shift_a = 1'b0; shift_b = 1'b0;
        @(negedge clk);
        scan_bits(32'd0, pat(6), 32, "R10 overlap ignored");

        finish_up();
    end

endmodule